// File: doc/BRIEF.md
# Selectable-Mode Fixed-Point Rounding Stage

This block shortens a signed two's-complement fixed-point word by removing a fixed number of low fractional bits. The result is one output LSB coarser than the input. A 3-bit mode input picks the rounding rule on every sample, so one datapath can serve code paths that need different biases. The six rules are truncation toward zero, ceiling, floor, round-half-up, round-half-down and ties-to-even.

The stage works out one increment bit from the sign, the discarded bits and the kept LSB, then adds it to the kept part. The only place the result can exceed its range is when that increment leaves the largest positive output code. There the block raises an overflow flag, and a build parameter chooses between clamping and wrapping. An optional output register gives the stage one cycle of latency; otherwise it is purely combinational.

Top module: `fxp_rounder`

## Requirements
- R1: Mode code 2 (floor) gives the largest output value not above the input, which equals an arithmetic right shift by DROP bits, and it never raises the overflow flag.
- R2: Mode codes 0, 6 and 7 (truncate) round toward zero. A negative input with any nonzero discarded bit ends one output LSB above its floor, and every other input gives its floor.
- R3: Mode code 1 (ceiling) gives the smallest output value not below the input. Example: +1.375 gives +2 and −1.375 gives −1.
- R4: Mode code 3 (half-up) adds one output LSB when the discarded fraction is at least one half, so +0.5 gives +1 and −0.5 gives 0.
- R5: Mode code 4 (half-down) adds one output LSB only when the discarded fraction is strictly above one half, so an exact tie rounds down.
- R6: Mode code 5 (ties-to-even) rounds to the nearest value and breaks an exact tie toward the even output. Examples: ±0.5 gives 0 and ±1.5 gives ±2.
- R7: When an increment would pass the largest positive output code, out_ovf is 1. With SATURATE=1, out_data is then the largest positive code.
- R8: With SATURATE=0, an overflowing increment wraps out_data to the most negative code while out_ovf is 1.
- R9: With DROP=0, every mode passes in_data through unchanged and out_ovf stays 0.
- R10: With REGISTERED=1, out_valid equals in_valid one cycle later. out_data and out_ovf load only in a cycle where in_valid is 1 and hold while it is 0.
- R11: During reset (rst_n low), out_valid, out_data and out_ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks in_data as a sample to process |
| in_data | input | IN_W | Wide signed input word |
| mode | input | 3 | Rounding rule select (encoding in R1 to R6) |
| out_valid | output | 1 | Marks out_data as a result |
| out_data | output | IN_W-DROP | Narrowed signed result |
| out_ovf | output | 1 | Set when the rounding increment overflowed |

## Verification
Every 8-bit input value with three dropped bits is applied under all eight mode codes. This covers every discarded-fraction pattern on both signs: zero, below half, exact tie and above half. Those are the cases that separate the six rules. The ties ±0.5 and ±1.5 are then applied again on their own, because they alone distinguish half-up, half-down and ties-to-even, and they check the sign handling of truncation. Saturating, wrapping and zero-drop builds receive the same stream, with idle gaps between samples to check that the output holds.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    typedef enum logic [2:0] {
        RM_TOWARD_ZERO = 3'd0,
        RM_CEIL        = 3'd1,
        RM_FLOOR       = 3'd2,
        RM_HALF_UP     = 3'd3,
        RM_HALF_DOWN   = 3'd4,
        RM_TIES_EVEN   = 3'd5,
        RM_SPARE_6     = 3'd6,
        RM_SPARE_7     = 3'd7
    } rmode_t;

    // Summary of the bits being thrown away.
    typedef struct packed {
        logic neg;     // input sign
        logic any;     // some discarded bit is set
        logic half;    // top discarded bit
        logic below;   // some discarded bit under the top one is set
    } frac_flags_t;

endpackage

// File: rtl/fxr_split.sv
module fxr_split #(
    parameter int IN_W = 16,
    parameter int DROP = 4
) (
    input  logic [IN_W-1:0]      din,
    output logic [IN_W-DROP-1:0] kept,
    output fxr_pkg::frac_flags_t flags
);
    localparam int OUT_W = IN_W - DROP;

    logic [DROP-1:0] disc;

    assign kept       = din[IN_W-1 -: OUT_W];
    assign disc       = din[DROP-1:0];
    assign flags.neg  = din[IN_W-1];
    assign flags.any  = |disc;
    assign flags.half = disc[DROP-1];

    generate
        if (DROP >= 2) begin : g_low
            assign flags.below = |disc[DROP-2:0];
        end else begin : g_single
            assign flags.below = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fxr_decide.sv
module fxr_decide
    import fxr_pkg::*;
(
    input  rmode_t      mode,
    input  frac_flags_t flags,
    input  logic        kept_lsb,
    output logic        inc
);
    logic tie;
    logic over_half;

    assign tie       = flags.half & ~flags.below;
    assign over_half = flags.half &  flags.below;

    always_comb begin
        unique case (mode)
            RM_CEIL:      inc = flags.any;
            RM_FLOOR:     inc = 1'b0;
            RM_HALF_UP:   inc = flags.half;
            RM_HALF_DOWN: inc = over_half;
            RM_TIES_EVEN: inc = over_half | (tie & kept_lsb);
            RM_TOWARD_ZERO,
            RM_SPARE_6,
            RM_SPARE_7:   inc = flags.neg & flags.any;
        endcase
    end

endmodule

// File: rtl/fxr_adjust.sv
module fxr_adjust #(
    parameter int OUT_W    = 12,
    parameter bit SATURATE = 1'b1
) (
    input  logic [OUT_W-1:0] kept,
    input  logic             inc,
    output logic [OUT_W-1:0] res,
    output logic             ovf
);
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

    logic [OUT_W-1:0] bumped;

    assign bumped = kept + {{(OUT_W-1){1'b0}}, inc};
    assign ovf    = inc & (kept == POS_MAX);

    generate
        if (SATURATE) begin : g_clamp
            assign res = ovf ? POS_MAX : bumped;
        end else begin : g_wrap
            assign res = bumped;
        end
    endgenerate

endmodule

// File: rtl/fxp_rounder.sv
module fxp_rounder #(
    parameter int IN_W       = 16,
    parameter int DROP       = 4,
    parameter bit SATURATE   = 1'b1,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      in_data,
    input  logic [2:0]           mode,
    output logic                 out_valid,
    output logic [IN_W-DROP-1:0] out_data,
    output logic                 out_ovf
);
    import fxr_pkg::*;

    localparam int OUT_W = IN_W - DROP;

    logic [OUT_W-1:0] nxt_data;
    logic             nxt_ovf;

    generate
        if (DROP == 0) begin : g_pass
            assign nxt_data = in_data;
            assign nxt_ovf  = 1'b0;
        end else begin : g_round
            logic [OUT_W-1:0] kept;
            frac_flags_t      flags;
            logic             inc;

            fxr_split #(.IN_W(IN_W), .DROP(DROP)) u_split (
                .din   (in_data),
                .kept  (kept),
                .flags (flags)
            );

            fxr_decide u_decide (
                .mode     (rmode_t'(mode)),
                .flags    (flags),
                .kept_lsb (kept[0]),
                .inc      (inc)
            );

            fxr_adjust #(.OUT_W(OUT_W), .SATURATE(SATURATE)) u_adjust (
                .kept (kept),
                .inc  (inc),
                .res  (nxt_data),
                .ovf  (nxt_ovf)
            );
        end

        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_data  <= '0;
                    out_ovf   <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_data <= nxt_data;
                        out_ovf  <= nxt_ovf;
                    end
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_data  = nxt_data;
            assign out_ovf   = nxt_ovf;
        end
    endgenerate

endmodule

// File: rtl/fxp_rounder_chk.sv
module fxp_rounder_chk #(
    parameter int IN_W       = 16,
    parameter int DROP       = 4,
    parameter bit SATURATE   = 1'b1,
    parameter bit REGISTERED = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [IN_W-1:0]      in_data,
    input logic [2:0]           mode,
    input logic                 out_valid,
    input logic [IN_W-DROP-1:0] out_data,
    input logic                 out_ovf
);
    localparam int OUT_W = IN_W - DROP;
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] floor_val;
    assign floor_val = in_data[IN_W-1 -: OUT_W];

    generate
        if (SATURATE) begin : g_sat
            assert_ovf_clamps_R7: assert property (@(posedge clk) disable iff (!rst_n)
                out_ovf |-> out_data == POS_MAX);
        end else begin : g_wrap
            assert_ovf_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
                out_ovf |-> out_data == NEG_MIN);
        end

        if (REGISTERED) begin : g_reg
            assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_data) && $stable(out_ovf));
            assert_floor_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 3'd2) |=> (out_data == $past(floor_val)) && !out_ovf);
            if (DROP == 0) begin : g_pass
                assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid |=> !out_ovf);
            end
        end
    endgenerate

endmodule

bind fxp_rounder fxp_rounder_chk #(
    .IN_W(IN_W), .DROP(DROP), .SATURATE(SATURATE), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/fxp_rounder_bench.sv
module fxp_rounder_bench;
    localparam int IN_W  = 8;
    localparam int DROP  = 3;
    localparam int OUT_W = IN_W - DROP;
    localparam int SCALE = 1 << DROP;
    localparam int PMAX  = (1 << (OUT_W - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic [2:0] mode = 3'd0;

    logic             sv_v, wr_v, ps_v;
    logic [OUT_W-1:0] sv_d, wr_d;
    logic [IN_W-1:0]  ps_d;
    logic             sv_o, wr_o, ps_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fxp_rounder #(.IN_W(IN_W), .DROP(DROP), .SATURATE(1'b1), .REGISTERED(1'b1)) u_fxp_rounder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
        .out_valid(sv_v), .out_data(sv_d), .out_ovf(sv_o));

    fxp_rounder #(.IN_W(IN_W), .DROP(DROP), .SATURATE(1'b0), .REGISTERED(1'b1)) u_wrap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
        .out_valid(wr_v), .out_data(wr_d), .out_ovf(wr_o));

    fxp_rounder #(.IN_W(IN_W), .DROP(0), .SATURATE(1'b1), .REGISTERED(1'b1)) u_pass (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
        .out_valid(ps_v), .out_data(ps_d), .out_ovf(ps_o));

    typedef struct {
        bit    vld;
        int    sat_d;
        int    wrp_d;
        bit    ovf;
        int    pas_d;
        string tag;
    } exp_t;

    exp_t pending[$];
    exp_t last;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input int md);
        case (md)
            1: return "R3";
            2: return "R1";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R2";
        endcase
    endfunction

    // Integer model of the rounding rules.
    function automatic int model_round(input int v, input int md);
        int fl, rem, r;
        fl  = (v >= 0) ? v / SCALE : -((-v + SCALE - 1) / SCALE);
        rem = v - fl * SCALE;
        case (md)
            1: r = fl + ((rem != 0) ? 1 : 0);
            2: r = fl;
            3: r = fl + ((2 * rem >= SCALE) ? 1 : 0);
            4: r = fl + ((2 * rem > SCALE) ? 1 : 0);
            5: begin
                if (2 * rem > SCALE) r = fl + 1;
                else if (2 * rem == SCALE) r = fl + ((fl % 2 != 0) ? 1 : 0);
                else r = fl;
            end
            default: r = v / SCALE;
        endcase
        return r;
    endfunction

    task automatic compare_outputs();
        exp_t e;
        if (pending.size() == 0) return;
        e = pending.pop_front();
        check("R10 valid", int'(sv_v), int'(e.vld));
        check("R10 valid", int'(ps_v), int'(e.vld));
        check({e.tag, " sat"}, int'($signed(sv_d)), e.sat_d);
        check(e.ovf ? "R7 flag" : {e.tag, " flag"}, int'(sv_o), int'(e.ovf));
        check(e.ovf ? "R8 wrap" : {e.tag, " wrap"}, int'($signed(wr_d)), e.wrp_d);
        check("R8 flag", int'(wr_o), int'(e.ovf));
        check("R9 data", int'($signed(ps_d)), e.pas_d);
        check("R9 flag", int'(ps_o), 0);
    endtask

    task automatic step(input bit vld, input int v, input int md);
        exp_t e;
        int r;
        @(negedge clk);
        compare_outputs();
        in_valid = vld;
        in_data  = IN_W'(v);
        mode     = 3'(md);
        e = last;
        e.vld = vld;
        if (vld) begin
            r = model_round(v, md);
            e.tag = mode_tag(md);
            e.ovf = (r > PMAX);
            e.sat_d = e.ovf ? PMAX : r;
            e.wrp_d = e.ovf ? r - 2 * (PMAX + 1) : r;
            e.pas_d = v;
            last = e;
        end else begin
            e.tag = "R10 hold";
        end
        pending.push_back(e);
    endtask

    initial begin
        last = '{vld: 1'b0, sat_d: 0, wrp_d: 0, ovf: 1'b0, pas_d: 0, tag: "R11"};
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 valid", int'(sv_v), 0);
        check("R11 data", int'(sv_d), 0);
        check("R11 flag", int'(sv_o), 0);
        check("R11 data", int'(ps_d), 0);
        rst_n = 1'b1;

        // Exhaustive sweep, all codes, idle gaps for R10 hold
        for (int md = 0; md < 8; md++) begin
            for (int v = -(1 << (IN_W - 1)); v < (1 << (IN_W - 1)); v++) begin
                step(1'b1, v, md);
                if ((v & 31) == 7) step(1'b0, (v * 5) & 127, (md + 3) & 7);
            end
        end

        // Signed ties +-0.5 and +-1.5 (R4, R5, R6, R2)
        for (int md = 0; md < 6; md++) begin
            step(1'b1,  SCALE / 2, md);
            step(1'b1, -SCALE / 2, md);
            step(1'b1,  3 * SCALE / 2, md);
            step(1'b1, -3 * SCALE / 2, md);
        end
        // Overflow corner: largest input under ceiling (R7, R8)
        step(1'b1, (1 << (IN_W - 1)) - 1, 1);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule